// File: doc/BRIEF.md
# Serial Programming Command Target

This block is the receiving end of a two-wire serial program and verify port. An external programmer toggles a serial clock and moves bits on one shared data line. The target samples the line on each falling serial clock edge and collects 20-bit frames. Each frame is a 4-bit command followed by a 16-bit operand, and both fields arrive least significant bit first. The block runs on its own system clock and oversamples the serial clock, so every serial event becomes a one-cycle event in the system domain.

A decoded command does one of four things:
- It reads a byte from a small internal byte memory into a table latch. The table pointer may be adjusted first or afterwards.
- It writes the low operand byte at the pointer, with an optional start-programming pulse.
- It shifts the current latch contents back out.
- It forwards the operand as a core instruction on an output port with a one-cycle strobe.

On commands that return data, the target drives the second half of the operand. The data line is split into an input, an output and an output enable, and the pad logic combines them.

Top module: `serprog_target`

## Requirements
- R1: While rst is high, and after it is released, the frame bit counter is at the first command bit, the pointer is 0, the table latch is 0, ser_doe is low and both strobes are low. Asserting rst in the middle of a frame discards the partial frame.
- R2: ser_din is sampled on each falling edge of ser_clk. A frame is 4 command bits followed by 16 operand bits, both least significant bit first, so frame bit 4 is operand bit 0. Every frame is exactly 20 falling edges long.
- R3: Command 0000 copies the 16-bit operand to core_insn after the 20th falling edge and raises core_valid for exactly one clk cycle.
- R4: Write commands 1100, 1101, 1110 and 1111 store operand bits 7..0 (frame bits 4..11) at the pointer and also load them into the table latch. Operand bits 15..8 are ignored.
- R5: After its store, 1100 and 1111 leave the pointer unchanged, and 1101 and 1110 add 2 to it. All pointer arithmetic wraps modulo the memory depth.
- R6: Commands 1110 and 1111 raise prog_pulse for exactly one clk cycle. prog_addr then holds the address that the store used.
- R7: When the command phase ends, read commands load the latch from memory. 1000 reads at the pointer and leaves it unchanged. 1001 reads at the pointer and then increments it. 1010 reads at the pointer and then decrements it. 1011 increments the pointer and then reads at the new value.
- R8: On commands 0010 and 1000..1011, operand bits 0..7 are ignored inputs. From the rising edge that opens frame bit 12, the target drives the latch byte on ser_dout, least significant bit first, one bit per serial clock, with ser_doe high. It releases ser_doe at the falling edge that ends frame bit 19.
- R9: Command 0010 returns the current latch contents without reading memory and without moving the pointer.
- R10: Undefined codes 0001 and 0011..0111 store nothing, leave the pointer and latch unchanged, raise no strobe, and still take 20 serial clocks.
- R11: Commands that do not return data never raise ser_doe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial port |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial programming clock from the programmer |
| ser_din | input | 1 | Serial data line as seen by the target |
| ser_dout | output | 1 | Data bit driven back during read frames |
| ser_doe | output | 1 | High while the target owns the data line |
| core_insn | output | 16 | Last core-instruction operand received |
| core_valid | output | 1 | One-cycle strobe for core_insn |
| prog_pulse | output | 1 | One-cycle start-programming pulse |
| prog_addr | output | ADDR_W | Address written by the programming command |

## Verification
The bench builds the block with its defaults: ADDR_W of 8, which gives a 256-byte memory, and two synchronizer stages. It runs the serial clock at sixteen system clocks per bit. With an 8-bit pointer, a post-decrement from address 0 and a post-increment from address 255 each take a single frame, so wrap-around is checked in both directions. Two synchronizer stages put every internal event well inside each serial half period. That makes it possible to check line ownership, frame bit by frame bit, against the bench's own model of pointer, latch and memory.

// File: rtl/spt_pkg.sv
package spt_pkg;

    localparam int CMD_W     = 4;
    localparam int OPND_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int FRAME_LEN = CMD_W + OPND_W;
    localparam int OUT_START = FRAME_LEN - BYTE_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int BIT_W     = $clog2(BYTE_W);

    localparam logic [CMD_W-1:0] OP_CORE      = 4'b0000;
    localparam logic [CMD_W-1:0] OP_LATCH_OUT = 4'b0010;
    localparam logic [CMD_W-1:0] OP_RD        = 4'b1000;
    localparam logic [CMD_W-1:0] OP_RD_POSTI  = 4'b1001;
    localparam logic [CMD_W-1:0] OP_RD_POSTD  = 4'b1010;
    localparam logic [CMD_W-1:0] OP_RD_PREI   = 4'b1011;
    localparam logic [CMD_W-1:0] OP_WR        = 4'b1100;
    localparam logic [CMD_W-1:0] OP_WR_STEP2  = 4'b1101;
    localparam logic [CMD_W-1:0] OP_WR_PG_ST2 = 4'b1110;
    localparam logic [CMD_W-1:0] OP_WR_PG     = 4'b1111;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_INC,
        STEP_DEC,
        STEP_INC2
    } step_e;

    typedef struct packed {
        logic  core;    // operand goes to the core-instruction port
        logic  drives;  // second operand byte is driven by the target
        logic  mem_rd;  // latch loaded from memory at end of command phase
        logic  pre;     // pointer adjusted before the read
        logic  wr;      // low operand byte stored at end of frame
        logic  prog;    // start-programming pulse
        step_e step;    // pointer adjustment
    } dec_t;

    function automatic dec_t decode(input logic [CMD_W-1:0] c);
        dec_t d;
        d = '{core: 1'b0, drives: 1'b0, mem_rd: 1'b0, pre: 1'b0,
              wr: 1'b0, prog: 1'b0, step: STEP_NONE};
        case (c)
            OP_CORE:      d.core = 1'b1;
            OP_LATCH_OUT: d.drives = 1'b1;
            OP_RD:        begin d.drives = 1'b1; d.mem_rd = 1'b1; end
            OP_RD_POSTI:  begin d.drives = 1'b1; d.mem_rd = 1'b1; d.step = STEP_INC; end
            OP_RD_POSTD:  begin d.drives = 1'b1; d.mem_rd = 1'b1; d.step = STEP_DEC; end
            OP_RD_PREI:   begin d.drives = 1'b1; d.mem_rd = 1'b1; d.pre = 1'b1;
                                d.step = STEP_INC; end
            OP_WR:        d.wr = 1'b1;
            OP_WR_STEP2:  begin d.wr = 1'b1; d.step = STEP_INC2; end
            OP_WR_PG_ST2: begin d.wr = 1'b1; d.prog = 1'b1; d.step = STEP_INC2; end
            OP_WR_PG:     begin d.wr = 1'b1; d.prog = 1'b1; end
            default:      ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/spt_edge_sync.sv
module spt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_din,
    output logic rise,
    output logic fall,
    output logic din_s
);
    localparam int MSB = STAGES - 1;

    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] dat_sh;
    logic              clk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sh   <= '0;
            dat_sh   <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_sh   <= {clk_sh[MSB-1:0], ser_clk};
            dat_sh   <= {dat_sh[MSB-1:0], ser_din};
            clk_prev <= clk_sh[MSB];
        end
    end

    assign rise  =  clk_sh[MSB] & ~clk_prev;
    assign fall  = ~clk_sh[MSB] &  clk_prev;
    assign din_s =  dat_sh[MSB];
endmodule

// File: rtl/spt_frame.sv
module spt_frame
    import spt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  logic                fall,
    input  logic                din,
    input  logic [BYTE_W-1:0]   rd_byte,
    output logic                cmd_done,
    output logic [CMD_W-1:0]    cmd_next,
    output logic                frame_done,
    output logic [CMD_W-1:0]    cmd_q,
    output logic [OPND_W-1:0]   operand,
    output logic                dout,
    output logic                oe,
    output logic [CNT_W-1:0]    bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] FIRST_RD = CNT_W'(OUT_START);

    logic [FRAME_LEN-1:0] sh;
    logic [CNT_W-1:0]     out_off;

    assign cmd_next   = {din, sh[FRAME_LEN-1 -: CMD_W-1]};
    assign operand    = {din, sh[FRAME_LEN-1 -: OPND_W-1]};
    assign cmd_done   = fall && (bit_cnt == LAST_CMD);
    assign frame_done = fall && (bit_cnt == LAST_BIT);
    assign out_off    = bit_cnt - FIRST_RD;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            sh      <= '0;
            cmd_q   <= '0;
            dout    <= 1'b0;
            oe      <= 1'b0;
        end else if (fall) begin
            sh      <= {din, sh[FRAME_LEN-1:1]};
            bit_cnt <= frame_done ? '0 : bit_cnt + 1'b1;
            if (cmd_done)
                cmd_q <= cmd_next;
            if (frame_done) begin
                oe   <= 1'b0;
                dout <= 1'b0;
            end
        end else if (rise && bit_cnt >= FIRST_RD) begin
            dout <= rd_byte[out_off[BIT_W-1:0]];
            oe   <= decode(cmd_q).drives;
        end
    end
endmodule

// File: rtl/spt_table.sv
module spt_table
    import spt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_done,
    input  logic [CMD_W-1:0]   cmd_next,
    input  logic               frame_done,
    input  logic [CMD_W-1:0]   cmd_q,
    input  logic [OPND_W-1:0]  operand,
    output logic [BYTE_W-1:0]  latch,
    output logic [OPND_W-1:0]  core_insn,
    output logic               core_valid,
    output logic               prog_pulse,
    output logic [ADDR_W-1:0]  prog_addr
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] rd_addr;
    dec_t              dr;
    dec_t              dw;

    function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] p,
                                                  input step_e s);
        case (s)
            STEP_INC:  return p + ADDR_W'(1);
            STEP_DEC:  return p - ADDR_W'(1);
            STEP_INC2: return p + ADDR_W'(2);
            default:   return p;
        endcase
    endfunction

    assign dr      = decode(cmd_next);
    assign dw      = decode(cmd_q);
    assign rd_addr = dr.pre ? ptr + ADDR_W'(1) : ptr;

    always_ff @(posedge clk) begin
        if (frame_done && dw.wr)
            mem[ptr] <= operand[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            latch      <= '0;
            core_insn  <= '0;
            core_valid <= 1'b0;
            prog_pulse <= 1'b0;
            prog_addr  <= '0;
        end else begin
            core_valid <= 1'b0;
            prog_pulse <= 1'b0;
            if (cmd_done && dr.mem_rd) begin
                latch <= mem[rd_addr];
                ptr   <= advance(ptr, dr.step);
            end
            if (frame_done) begin
                if (dw.wr) begin
                    latch <= operand[BYTE_W-1:0];
                    ptr   <= advance(ptr, dw.step);
                end
                if (dw.prog) begin
                    prog_pulse <= 1'b1;
                    prog_addr  <= ptr;
                end
                if (dw.core) begin
                    core_insn  <= operand;
                    core_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serprog_target.sv
module serprog_target
    import spt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_doe,
    output logic [15:0]       core_insn,
    output logic              core_valid,
    output logic              prog_pulse,
    output logic [ADDR_W-1:0] prog_addr
);
    logic               ev_rise;
    logic               ev_fall;
    logic               din_s;
    logic               cmd_done;
    logic               frame_done;
    logic [CMD_W-1:0]   cmd_next;
    logic [CMD_W-1:0]   cmd_q;
    logic [OPND_W-1:0]  operand;
    logic [BYTE_W-1:0]  latch;
    logic [CNT_W-1:0]   frame_cnt;

    spt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_din (ser_din),
        .rise    (ev_rise),
        .fall    (ev_fall),
        .din_s   (din_s)
    );

    spt_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .rise       (ev_rise),
        .fall       (ev_fall),
        .din        (din_s),
        .rd_byte    (latch),
        .cmd_done   (cmd_done),
        .cmd_next   (cmd_next),
        .frame_done (frame_done),
        .cmd_q      (cmd_q),
        .operand    (operand),
        .dout       (ser_dout),
        .oe         (ser_doe),
        .bit_cnt    (frame_cnt)
    );

    spt_table #(.ADDR_W(ADDR_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .cmd_done   (cmd_done),
        .cmd_next   (cmd_next),
        .frame_done (frame_done),
        .cmd_q      (cmd_q),
        .operand    (operand),
        .latch      (latch),
        .core_insn  (core_insn),
        .core_valid (core_valid),
        .prog_pulse (prog_pulse),
        .prog_addr  (prog_addr)
    );
endmodule

// File: rtl/spt_checker.sv
module spt_checker
    import spt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] frame_cnt,
    input logic             ser_doe,
    input logic             core_valid,
    input logic             prog_pulse
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (frame_cnt == '0 && !ser_doe && !core_valid && !prog_pulse));

    assert_cnt_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        frame_cnt <= CNT_W'(FRAME_LEN - 1));

    assert_core_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        core_valid |=> !core_valid);

    assert_prog_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        prog_pulse |=> !prog_pulse);

    assert_no_both_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        !(core_valid && prog_pulse));

    assert_drive_window_R8: assert property (@(posedge clk) disable iff (rst)
        ser_doe |-> frame_cnt >= CNT_W'(OUT_START));
endmodule

bind serprog_target spt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_cnt  (frame_cnt),
    .ser_doe    (ser_doe),
    .core_valid (core_valid),
    .prog_pulse (prog_pulse)
);

// File: tb/serprog_target_tb.sv
module serprog_target_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic        ser_doe;
    logic [15:0] core_insn;
    logic        core_valid;
    logic        prog_pulse;
    logic [7:0]  prog_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int          kind;   // 0 core, 1 prog, 2 read byte
        logic [15:0] val;
        string       req;
    } exp_t;
    exp_t sbq[$];

    logic [7:0] mem_m [256];
    logic [7:0] ptr_m   = 8'h00;
    logic [7:0] latch_m = 8'h00;

    always #5 clk = ~clk;

    serprog_target u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_dout(ser_dout), .ser_doe(ser_doe), .core_insn(core_insn),
        .core_valid(core_valid), .prog_pulse(prog_pulse), .prog_addr(prog_addr)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic observe(input int kind, input logic [15:0] v);
        exp_t e;
        if (sbq.size() == 0) begin
            chk(1'b0, "R10", v, 16'hxxxx);
        end else begin
            e = sbq.pop_front();
            chk(e.kind == kind && e.val == v, e.req, v, e.val);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (core_valid) observe(0, core_insn);
            if (prog_pulse) observe(1, {8'h00, prog_addr});
        end
    end

    task automatic push(input int kind, input logic [15:0] v, input string req);
        exp_t e;
        e.kind = kind; e.val = v; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic send_frame(input logic [3:0] c, input logic [15:0] op, input string req);
        bit         rd = (c == 4'b0010) || (c[3:2] == 2'b10);
        bit         oe_bad = 1'b0;
        logic [7:0] got = 8'h00;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_clk = 1'b1;
            ser_din = (i < 4) ? c[i] : op[i-4];
            repeat (HALF) @(negedge clk);
            if (rd && i >= 12) begin
                if (!ser_doe) oe_bad = 1'b1;
                got[i-12] = ser_dout;
            end else if (ser_doe) begin
                oe_bad = 1'b1;
            end
            ser_clk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
        repeat (HALF) @(negedge clk);
        // R8 / R11: ownership of the data line during and after the frame
        chk(!oe_bad && !ser_doe, rd ? "R8" : "R11", {15'd0, ser_doe}, 16'd0);
        if (rd) observe(2, {8'h00, got});
        if (req == "R10") chk(sbq.size() == 0, "R10", 16'(sbq.size()), 16'd0);
    endtask

    task automatic do_cmd(input logic [3:0] c, input logic [15:0] op, input string req);
        case (c)
            4'b0000: push(0, op, req);
            4'b0010: push(2, {8'h00, latch_m}, req);
            4'b1000: begin latch_m = mem_m[ptr_m]; push(2, {8'h00, latch_m}, req); end
            4'b1001: begin latch_m = mem_m[ptr_m]; ptr_m++; push(2, {8'h00, latch_m}, req); end
            4'b1010: begin latch_m = mem_m[ptr_m]; ptr_m--; push(2, {8'h00, latch_m}, req); end
            4'b1011: begin ptr_m++; latch_m = mem_m[ptr_m]; push(2, {8'h00, latch_m}, req); end
            4'b1100, 4'b1101, 4'b1110, 4'b1111: begin
                mem_m[ptr_m] = op[7:0];
                latch_m = op[7:0];
                if (c[1]) push(1, {8'h00, ptr_m}, req);
                if (c == 4'b1101 || c == 4'b1110) ptr_m = ptr_m + 8'd2;
            end
            default: ;
        endcase
        send_frame(c, op, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 16'd0, 16'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: state while in reset
        chk(!ser_doe && !core_valid && !prog_pulse, "R1",
            {13'd0, ser_doe, core_valid, prog_pulse}, 16'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!ser_doe && !core_valid && !prog_pulse, "R1",
            {13'd0, ser_doe, core_valid, prog_pulse}, 16'd0);

        do_cmd(4'b0000, 16'hA5C3, "R3");
        do_cmd(4'b0000, 16'h0001, "R2");
        do_cmd(4'b1101, 16'h7E11, "R4");
        do_cmd(4'b1110, 16'hBB22, "R6");
        do_cmd(4'b1100, 16'h0033, "R4");
        do_cmd(4'b1111, 16'h0044, "R6");
        do_cmd(4'b1010, 16'h00FF, "R7");
        do_cmd(4'b1100, 16'h0099, "R5");
        do_cmd(4'b1011, 16'h0000, "R7");
        do_cmd(4'b1010, 16'h0000, "R7");
        do_cmd(4'b1001, 16'h0000, "R7");
        do_cmd(4'b1000, 16'h0000, "R5");
        do_cmd(4'b1111, 16'h0066, "R6");
        do_cmd(4'b0010, 16'hABCD, "R9");
        do_cmd(4'b0101, 16'hFFFF, "R10");
        do_cmd(4'b1000, 16'h0000, "R10");

        // R1: reset in the middle of a frame
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); ser_clk = 1'b1; ser_din = i[0];
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        ptr_m = 8'h00;
        latch_m = 8'h00;
        repeat (4) @(negedge clk);
        chk(!ser_doe, "R1", {15'd0, ser_doe}, 16'd0);

        do_cmd(4'b0010, 16'h0000, "R1");
        do_cmd(4'b1010, 16'h0000, "R1");
        do_cmd(4'b1100, 16'h0077, "R5");
        do_cmd(4'b1001, 16'h0000, "R5");
        do_cmd(4'b1000, 16'h0000, "R5");

        repeat (20) @(negedge clk);
        chk(sbq.size() == 0, "R2", 16'(sbq.size()), 16'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule